// File: doc/BRIEF.md
# Inbound Mailbox Queue with Overwrite of the Newest Entry

This block holds up to four 32-bit words sent to a consumer by a producer. A write never waits. While there is room it appends the word. Once the queue holds four words, each further write replaces only the newest word, and the three older words stay untouched. A read returns the oldest word together with the number of words held before that read. A read count of zero means the queue was empty.

An empty read leaves a pending-waiter mark in the block. The next write clears that mark and pulses a wake-up output, so a sleeping consumer can be resumed. Three ordered slots hold the oldest words. A separate register always keeps the most recently written word and refills the third slot whenever a read shifts the queue.

A clear port empties the block. A preload port installs an occupancy and all four stored words at once, which allows a saved mailbox state to be restored.

Top module: `inbox_queue`

## Requirements
- R1: After reset `fill_o` is 0 and `wake_o` is 0.
- R2: A write (`wr_en`) with fill below 4 appends `wr_data` behind the held words and raises `fill_o` by one on the next cycle. Reads return words in the order they were written.
- R3: A write while four words are held keeps `fill_o` at 4, replaces only the newest word and leaves the three older words in place.
- R4: While `rd_en` is high, `rd_data` shows the oldest word and `rd_count` shows the fill before removal. A read with a nonzero count removes that word and lowers `fill_o` by one.
- R5: A read with fill 0 gives `rd_count` 0, leaves the fill at 0 and marks a waiting consumer.
- R6: The first write after a waiting mark pulses `wake_o` high for exactly one cycle, in the cycle after the write, and clears the mark. Later writes do not pulse it.
- R7: A read and a write in the same cycle act as the read first and then the write. At fill 0 this reports count 0, stores the word, ends at fill 1 and pulses `wake_o`. At fill 4 it returns the oldest word, ends at fill 4, and the new word becomes the newest.
- R8: `clr_en` empties the queue and drops the waiting mark, so the next cycle shows fill 0.
- R9: `ld_en` sets the fill to `ld_count` (values above 4 are taken as 4) and stores `ld_w0` (oldest) to `ld_w3`. The loaded words are read back in that order, and any waiting mark is dropped.
- R10: Priority is clear, then preload, then read and write. Read and write requests in a cycle with `clr_en` or `ld_en` have no effect on the state and give no wake pulse.
- R11: `fill_o` always shows the current number of held words, in the range 0 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_en | input | 1 | Empty the queue |
| ld_en | input | 1 | Preload fill and words |
| ld_count | input | 3 | Preload fill (clamped to 4) |
| ld_w0 | input | 32 | Preload oldest word |
| ld_w1 | input | 32 | Preload second word |
| ld_w2 | input | 32 | Preload third word |
| ld_w3 | input | 32 | Preload fourth word / newest-word register |
| wr_en | input | 1 | Write request |
| wr_data | input | 32 | Word to write |
| rd_en | input | 1 | Read request |
| rd_data | output | 32 | Oldest word (valid when read count is nonzero) |
| rd_count | output | 3 | Fill before removal; 0 means the read failed |
| wake_o | output | 1 | One-cycle pulse after a write that ends a wait |
| fill_o | output | 3 | Current number of held words |

## Verification
The assertions assume that `ld_count` never goes above 4 at a preload, so that the fill stays inside its legal range. The stimulus keeps to this rule except on one preload that checks the clamp. The assertions also take control inputs as known and stable around each rising edge. The bench meets this by driving every input on the falling edge and releasing it after the rising edge.

// File: rtl/inbox_queue.sv
module inbox_queue #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_en,
  input  logic         ld_en,
  input  logic [2:0]   ld_count,
  input  logic [W-1:0] ld_w0,
  input  logic [W-1:0] ld_w1,
  input  logic [W-1:0] ld_w2,
  input  logic [W-1:0] ld_w3,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic [2:0]   rd_count,
  output logic         wake_o,
  output logic [2:0]   fill_o
);
  localparam logic [2:0] FULL = 3'd4;

  logic [W-1:0] s0, s1, s2, newest;
  logic [2:0]   fill;
  logic         waiting;

  logic [W-1:0] a0, a1, a2, n0, n1, n2, nn;
  logic [2:0]   afill, nfill;
  logic         await, nwait, nwake;

  assign rd_data  = s0;
  assign rd_count = fill;
  assign fill_o   = fill;

  always_comb begin
    a0 = s0; a1 = s1; a2 = s2; afill = fill; await = waiting;
    if (rd_en) begin
      if (fill != 3'd0) begin
        a0 = s1; a1 = s2; a2 = newest;
        afill = fill - 3'd1;
        await = 1'b0;
      end else begin
        await = 1'b1;
      end
    end
    n0 = a0; n1 = a1; n2 = a2; nn = newest; nfill = afill; nwait = await; nwake = 1'b0;
    if (wr_en) begin
      nn = wr_data;
      case (afill)
        3'd0:    begin n0 = wr_data; nfill = 3'd1; end
        3'd1:    begin n1 = wr_data; nfill = 3'd2; end
        3'd2:    begin n2 = wr_data; nfill = 3'd3; end
        default: nfill = FULL;
      endcase
      nwake = await;
      nwait = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_en) begin
      s0 <= '0; s1 <= '0; s2 <= '0; newest <= '0;
      fill <= '0; waiting <= 1'b0; wake_o <= 1'b0;
    end else if (ld_en) begin
      s0 <= ld_w0; s1 <= ld_w1; s2 <= ld_w2; newest <= ld_w3;
      fill <= (ld_count > FULL) ? FULL : ld_count;
      waiting <= 1'b0; wake_o <= 1'b0;
    end else begin
      s0 <= n0; s1 <= n1; s2 <= n2; newest <= nn;
      fill <= nfill; waiting <= nwait; wake_o <= nwake;
    end
  end
endmodule

module inbox_queue_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clr_en,
  input logic       ld_en,
  input logic       wr_en,
  input logic       rd_en,
  input logic       wake_o,
  input logic [2:0] fill_o
);
  logic plain;
  assign plain = !clr_en && !ld_en;

  assert_fill_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fill_o <= 3'd4);
  assert_write_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    plain && wr_en && !rd_en && fill_o < 3'd4 |=> fill_o == $past(fill_o) + 3'd1);
  assert_full_stays_R3: assert property (@(posedge clk) disable iff (!rst_n)
    plain && wr_en && !rd_en && fill_o >= 3'd3 |=> fill_o == 3'd4);
  assert_read_shrinks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    plain && rd_en && !wr_en && fill_o != 3'd0 |=> fill_o == $past(fill_o) - 3'd1);
  assert_empty_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    plain && rd_en && !wr_en && fill_o == 3'd0 |=> fill_o == 3'd0 && !wake_o);
  assert_wake_follows_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> $past(wr_en));
  assert_swap_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    plain && rd_en && wr_en && fill_o == 3'd4 |=> fill_o == 3'd4);
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> fill_o == 3'd0 && !wake_o);
endmodule

bind inbox_queue inbox_queue_chk i_chk (
  .clk(clk), .rst_n(rst_n), .clr_en(clr_en), .ld_en(ld_en),
  .wr_en(wr_en), .rd_en(rd_en), .wake_o(wake_o), .fill_o(fill_o)
);

// File: tb/test_inbox_queue.sv
module test_inbox_queue;
  logic clk = 1'b0, rst_n = 1'b0;
  logic clr_en = 0, ld_en = 0, wr_en = 0, rd_en = 0;
  logic [2:0] ld_count = '0;
  logic [31:0] ld_w0 = '0, ld_w1 = '0, ld_w2 = '0, ld_w3 = '0, wr_data = '0;
  logic [31:0] rd_data;
  logic [2:0] rd_count, fill_o;
  logic wake_o;

  int runs = 0, fails = 0;
  logic [31:0] mdl[$];
  bit m_wait = 0, m_wake = 0;

  always #4 clk = ~clk;

  inbox_queue i_inbox_queue (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input bit c, input bit l, input int lc, input logic [31:0] w[4],
                      input bit wr, input logic [31:0] d, input bit rd, input string req);
    @(negedge clk);
    clr_en = c; ld_en = l; ld_count = 3'(lc);
    ld_w0 = w[0]; ld_w1 = w[1]; ld_w2 = w[2]; ld_w3 = w[3];
    wr_en = wr; wr_data = d; rd_en = rd;
    #1;
    m_wake = 0;
    if (c) begin
      mdl.delete(); m_wait = 0;
    end else if (l) begin
      mdl.delete(); m_wait = 0;
      for (int i = 0; i < ((lc > 4) ? 4 : lc); i++) mdl.push_back(w[i]);
    end else begin
      if (rd) begin
        chk(rd_count == 3'(mdl.size()), {req, " read count"}, rd_count, mdl.size());
        if (mdl.size() > 0) begin
          chk(rd_data == mdl[0], {req, " read data"}, rd_data, mdl[0]);
          void'(mdl.pop_front());
          m_wait = 0;
        end else m_wait = 1;
      end
      if (wr) begin
        if (m_wait) m_wake = 1;
        m_wait = 0;
        if (mdl.size() < 4) mdl.push_back(d);
        else mdl[3] = d;
      end
    end
    @(posedge clk); #1;
    clr_en = 0; ld_en = 0; wr_en = 0; rd_en = 0;
    chk(fill_o == 3'(mdl.size()), {req, " fill"}, fill_o, mdl.size());
    chk(wake_o == m_wake, {req, " wake"}, wake_o, m_wake);
  endtask

  logic [31:0] z[4] = '{0, 0, 0, 0};

  task automatic wr(input logic [31:0] d, input string r); step(0,0,0,z,1,d,0,r); endtask
  task automatic rd(input string r); step(0,0,0,z,0,0,1,r); endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(fill_o == 0, "R1 fill", fill_o, 0);
    chk(wake_o == 0, "R1 wake", wake_o, 0);
    rst_n = 1;
    // R2 / R4 ordered append and removal
    wr(32'h11, "R2"); wr(32'h22, "R2");
    rd("R4"); rd("R4");
    // R5 empty read, R6 wake once
    rd("R5");
    wr(32'h33, "R6"); wr(32'h44, "R6");
    // R3 overwrite newest once full
    wr(32'h55, "R3"); wr(32'h66, "R3"); wr(32'h77, "R3");
    chk(fill_o == 4, "R11 full", fill_o, 4);
    rd("R3"); rd("R3"); rd("R3"); rd("R3");
    // R7 simultaneous at empty and at full
    step(0,0,0,z,1,32'h88,1,"R7 empty");
    rd("R7");
    wr(1, "R7"); wr(2, "R7"); wr(3, "R7"); wr(4, "R7");
    step(0,0,0,z,1,32'h5,1,"R7 full");
    rd("R7"); rd("R7"); rd("R7"); rd("R7");
    // R9 preload, clamp, order, drops waiting
    step(0,1,3,'{32'ha,32'hb,32'hc,32'hd},0,0,0,"R9 load3");
    wr(32'he, "R9");
    rd("R9"); rd("R9"); rd("R9"); rd("R9");
    step(0,1,6,'{32'hf0,32'hf1,32'hf2,32'hf3},0,0,0,"R9 clamp");
    rd("R9"); rd("R9"); rd("R9"); rd("R9");
    rd("R9 wait");
    step(0,1,0,z,0,0,0,"R9 load0");
    wr(32'h99, "R9 no wake");
    // R8 clear, R10 priority
    wr(32'h12, "R8");
    rd("R8 drain"); rd("R8 drain"); rd("R8 wait");
    step(1,0,0,z,1,32'h13,1,"R10 clr+wr");
    rd("R8 empty");
    wr(32'h14, "R6 after clr");
    step(0,1,2,'{32'h21,32'h22,32'h23,32'h24},1,32'h66,1,"R10 ld+wr");
    rd("R10"); rd("R10");
    wr(32'h31, "R8"); wr(32'h32, "R8");
    step(1,0,0,z,0,0,0,"R8 clr");
    rd("R8 after");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule